// File: doc/BRIEF.md
# Time-Division Flit Width Adapter

This block sits between a wide module-side datapath and a narrow network link whose flits are a fixed 150 bits. On the send side it takes one word of up to 600 bits through a ready/valid handshake. It then puts the word on the link as a burst of one to four flits, one flit per cycle. The link therefore carries a quarter of the width at four times the word rate. The number of flits is chosen from a configured payload width in 150-bit bands. That width is sampled when a word is taken, and payload bits at or above it are forced to zero.

On the receive side the same block rebuilds words from flits. A head mark opens a new word and flits fill slices upward. The tail mark closes the word, which is then offered to the consumer with a valid/ready handshake and held until it is taken. Everything runs on one clock. The rate step between the module and the link is modelled as flits per word.

Top module: `tfa_flit_adapter`

## Requirements
- R1: The configured width `cfg_width` is sampled when a word is accepted and sets its flit count: 0 to 150 gives 1 flit, 151 to 300 gives 2, 301 to 450 gives 3, and 451 or more gives 4.
- R2: Flit k of a word carries bits [150k+149:150k] of the accepted word, lowest slice first. The flits appear on consecutive cycles, and the first one appears in the cycle after acceptance.
- R3: Every flit bit whose position in the word is at or above the sampled width is driven to zero.
- R4: `tx_flit_head` is high on the first flit of a word and `tx_flit_tail` on the last. A one-flit word has both high, and neither is high while `tx_flit_valid` is low.
- R5: `src_ready` is low while a word is being sent, except in the cycle that carries its tail flit. A word accepted in that cycle has its head flit in the very next cycle, with no idle gap.
- R6: After reset `src_ready` is high and both `tx_flit_valid` and `dst_valid` are low. `tx_flit_valid` is low whenever no word is in flight.
- R7: A change of `cfg_width` after a word is accepted has no effect on that word's flit count or masking.
- R8: A valid flit with `rx_flit_head` high starts a new word at slice 0, and each later valid flit fills the next slice. Slices that received no flit read as zero in the delivered word.
- R9: `dst_valid` rises in the cycle after a valid tail flit, if the output slot is free or being emptied. `dst_data` stays stable while `dst_valid` is high and `dst_ready` is low, and `dst_valid` falls after a handshake when nothing new completes.
- R10: A word whose tail arrives while the held output is still unaccepted is dropped, and the held word is kept unchanged.
- R11: Cycles with `rx_flit_valid` low change no slice, whatever the head, tail and data pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | CFG_W | Payload width in bits, sampled at acceptance |
| src_valid | input | 1 | Module-side word offered |
| src_ready | output | 1 | Adapter can accept a word this cycle |
| src_data | input | FLIT_W*MAX_SLICES | Module-side word |
| tx_flit_valid | output | 1 | Outgoing flit present |
| tx_flit_data | output | FLIT_W | Outgoing flit payload |
| tx_flit_head | output | 1 | Outgoing flit is first of its word |
| tx_flit_tail | output | 1 | Outgoing flit is last of its word |
| rx_flit_valid | input | 1 | Incoming flit present |
| rx_flit_data | input | FLIT_W | Incoming flit payload |
| rx_flit_head | input | 1 | Incoming flit opens a word |
| rx_flit_tail | input | 1 | Incoming flit closes a word |
| dst_valid | output | 1 | Rebuilt word available |
| dst_ready | input | 1 | Consumer takes the rebuilt word |
| dst_data | output | FLIT_W*MAX_SLICES | Rebuilt word |

## Verification
The send path is swept over widths on both sides of every band edge: 0, 1, 149, 150, 151, 300, 301, 450, 451, 599, 600 and a value above 600. Each width is tried with three bit patterns: all ones, a short-period pattern and a long-period pattern. All ones shows up masking errors at any bit position. The two periodic patterns tell apart slice swaps and off-by-one slice boundaries, which a uniform word would hide. The link loops back into the receive path, so each word must come back intact. Streams of four-flit and one-flit words show whether the handoff at the tail cycle leaves a gap or double-accepts. Directly driven receive flits, with invalid cycles carrying junk marks between them, tell whether the head reset, the slice fill order, the zeroing of unsent slices and the overrun drop behave as specified.

// File: rtl/tfa_pkg.sv
`timescale 1ns/1ps
package tfa_pkg;

   // Index of the last slice used by a payload of the given width.
   function automatic int last_slice_of(input int width, input int flit_w, input int max_s);
      int r;
      r = 0;
      for (int k = 1; k < max_s; k++) begin
         if (width > k * flit_w) r = k;
      end
      return r;
   endfunction

endpackage

// File: rtl/tfa_band_decode.sv
`timescale 1ns/1ps
module tfa_band_decode #(
   parameter int FLIT_W     = 150,
   parameter int MAX_SLICES = 4,
   parameter int CFG_W      = 10,
   parameter int CNT_W      = 2,
   localparam int WORD_W    = FLIT_W * MAX_SLICES
) (
   input  logic [CFG_W-1:0]  cfg_width,
   output logic [CNT_W-1:0]  last_idx,
   output logic [WORD_W-1:0] keep_mask
);

   always_comb begin
      last_idx = CNT_W'(tfa_pkg::last_slice_of(int'(cfg_width), FLIT_W, MAX_SLICES));
   end

   for (genvar b = 0; b < WORD_W; b++) begin : g_keep
      assign keep_mask[b] = (int'(cfg_width) > b);
   end

endmodule

// File: rtl/tfa_serializer.sv
`timescale 1ns/1ps
module tfa_serializer #(
   parameter int FLIT_W     = 150,
   parameter int MAX_SLICES = 4,
   parameter int CNT_W      = 2,
   localparam int WORD_W    = FLIT_W * MAX_SLICES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [WORD_W-1:0] src_data,
   input  logic [WORD_W-1:0] keep_mask,
   input  logic [CNT_W-1:0]  last_idx,
   output logic              tx_valid,
   output logic [FLIT_W-1:0] tx_data,
   output logic              tx_head,
   output logic              tx_tail
);

   logic              busy_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  last_q;
   logic [WORD_W-1:0] word_q;
   logic [FLIT_W-1:0] slice_w [MAX_SLICES];
   logic              take;

   for (genvar s = 0; s < MAX_SLICES; s++) begin : g_slice
      assign slice_w[s] = word_q[s*FLIT_W +: FLIT_W];
   end

   assign tx_valid  = busy_q;
   assign tx_data   = slice_w[idx_q];
   assign tx_head   = busy_q && (idx_q == '0);
   assign tx_tail   = busy_q && (idx_q == last_q);
   assign src_ready = !busy_q || tx_tail;
   assign take      = src_valid && src_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         word_q <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         last_q <= last_idx;
         word_q <= src_data & keep_mask;
      end else if (busy_q) begin
         if (tx_tail) busy_q <= 1'b0;
         else         idx_q  <= idx_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tfa_deserializer.sv
`timescale 1ns/1ps
module tfa_deserializer #(
   parameter int FLIT_W     = 150,
   parameter int MAX_SLICES = 4,
   parameter int CNT_W      = 2,
   localparam int WORD_W    = FLIT_W * MAX_SLICES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flit_valid,
   input  logic [FLIT_W-1:0] flit_data,
   input  logic              flit_head,
   input  logic              flit_tail,
   output logic              dst_valid,
   input  logic              dst_ready,
   output logic [WORD_W-1:0] dst_data
);

   logic [WORD_W-1:0] asm_q;
   logic [WORD_W-1:0] asm_next;
   logic [WORD_W-1:0] base;
   logic [CNT_W-1:0]  wr_idx_q;
   logic [CNT_W-1:0]  slot;
   logic [WORD_W-1:0] out_q;
   logic              vld_q;
   logic              deliver;
   logic              slot_free;

   assign slot = flit_head ? '0 : wr_idx_q;
   assign base = flit_head ? '0 : asm_q;

   for (genvar s = 0; s < MAX_SLICES; s++) begin : g_fill
      assign asm_next[s*FLIT_W +: FLIT_W] =
         (slot == CNT_W'(s)) ? flit_data : base[s*FLIT_W +: FLIT_W];
   end

   assign deliver   = flit_valid && flit_tail;
   assign slot_free = !vld_q || dst_ready;
   assign dst_valid = vld_q;
   assign dst_data  = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asm_q    <= '0;
         wr_idx_q <= '0;
      end else if (flit_valid) begin
         asm_q <= asm_next;
         if (flit_tail)                              wr_idx_q <= '0;
         else if (slot == CNT_W'(MAX_SLICES - 1))    wr_idx_q <= slot;
         else                                        wr_idx_q <= slot + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         out_q <= '0;
      end else if (deliver && slot_free) begin
         vld_q <= 1'b1;
         out_q <= asm_next;
      end else if (vld_q && dst_ready) begin
         vld_q <= 1'b0;
      end
   end

endmodule

// File: rtl/tfa_flit_adapter.sv
`timescale 1ns/1ps
module tfa_flit_adapter #(
   parameter int FLIT_W     = 150,
   parameter int MAX_SLICES = 4,
   parameter int CFG_W      = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CFG_W-1:0]             cfg_width,
   input  logic                         src_valid,
   output logic                         src_ready,
   input  logic [FLIT_W*MAX_SLICES-1:0] src_data,
   output logic                         tx_flit_valid,
   output logic [FLIT_W-1:0]            tx_flit_data,
   output logic                         tx_flit_head,
   output logic                         tx_flit_tail,
   input  logic                         rx_flit_valid,
   input  logic [FLIT_W-1:0]            rx_flit_data,
   input  logic                         rx_flit_head,
   input  logic                         rx_flit_tail,
   output logic                         dst_valid,
   input  logic                         dst_ready,
   output logic [FLIT_W*MAX_SLICES-1:0] dst_data
);

   localparam int WORD_W = FLIT_W * MAX_SLICES;
   localparam int CNT_W  = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1;

   if (FLIT_W < 1) begin : g_bad_flit
      $error("tfa_flit_adapter: FLIT_W must be at least 1");
   end
   if (MAX_SLICES < 1) begin : g_bad_slices
      $error("tfa_flit_adapter: MAX_SLICES must be at least 1");
   end
   if ((64'd1 << CFG_W) <= 64'(WORD_W)) begin : g_bad_cfg
      $error("tfa_flit_adapter: CFG_W too narrow to express the full word width");
   end

   logic [CNT_W-1:0]  last_idx;
   logic [WORD_W-1:0] keep_mask;

   tfa_band_decode #(
      .FLIT_W(FLIT_W), .MAX_SLICES(MAX_SLICES), .CFG_W(CFG_W), .CNT_W(CNT_W)
   ) u_band (
      .cfg_width (cfg_width),
      .last_idx  (last_idx),
      .keep_mask (keep_mask)
   );

   tfa_serializer #(
      .FLIT_W(FLIT_W), .MAX_SLICES(MAX_SLICES), .CNT_W(CNT_W)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_ready (src_ready),
      .src_data  (src_data),
      .keep_mask (keep_mask),
      .last_idx  (last_idx),
      .tx_valid  (tx_flit_valid),
      .tx_data   (tx_flit_data),
      .tx_head   (tx_flit_head),
      .tx_tail   (tx_flit_tail)
   );

   tfa_deserializer #(
      .FLIT_W(FLIT_W), .MAX_SLICES(MAX_SLICES), .CNT_W(CNT_W)
   ) u_des (
      .clk        (clk),
      .rst_n      (rst_n),
      .flit_valid (rx_flit_valid),
      .flit_data  (rx_flit_data),
      .flit_head  (rx_flit_head),
      .flit_tail  (rx_flit_tail),
      .dst_valid  (dst_valid),
      .dst_ready  (dst_ready),
      .dst_data   (dst_data)
   );

endmodule

// File: rtl/tfa_checker.sv
`timescale 1ns/1ps
module tfa_checker #(
   parameter int FLIT_W     = 150,
   parameter int MAX_SLICES = 4,
   parameter int CFG_W      = 10
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CFG_W-1:0]             cfg_width,
   input logic                         src_valid,
   input logic                         src_ready,
   input logic                         tx_flit_valid,
   input logic [FLIT_W-1:0]            tx_flit_data,
   input logic                         tx_flit_head,
   input logic                         tx_flit_tail,
   input logic                         rx_flit_valid,
   input logic                         rx_flit_tail,
   input logic                         dst_valid,
   input logic                         dst_ready,
   input logic [FLIT_W*MAX_SLICES-1:0] dst_data
);

   logic [CFG_W-1:0]  acc_w_q;
   logic [7:0]        slc_q;
   logic [FLIT_W-1:0] lane_keep;
   int                exp_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_w_q <= '0;
         slc_q   <= '0;
      end else if (src_valid && src_ready) begin
         acc_w_q <= cfg_width;
         slc_q   <= '0;
      end else if (tx_flit_valid && !tx_flit_tail) begin
         slc_q <= slc_q + 8'd1;
      end
   end

   always_comb begin
      exp_last = (int'(acc_w_q) == 0) ? 0 : (int'(acc_w_q) - 1) / FLIT_W;
      if (exp_last > MAX_SLICES - 1) exp_last = MAX_SLICES - 1;
      for (int b = 0; b < FLIT_W; b++) begin
         lane_keep[b] = (int'(slc_q) * FLIT_W + b) < int'(acc_w_q);
      end
   end

   a_r4_idle_no_marks: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_flit_valid |-> (!tx_flit_head && !tx_flit_tail));

   a_r5_ready_low_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flit_valid && !tx_flit_tail) |-> !src_ready);

   a_r5_head_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_ready) |=> (tx_flit_valid && tx_flit_head));

   a_r2_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flit_valid && !tx_flit_tail) |=> (tx_flit_valid && !tx_flit_head));

   a_r1_tail_at_band: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flit_valid && tx_flit_tail) |-> (int'(slc_q) == exp_last));

   a_r3_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flit_valid |-> ((tx_flit_data & ~lane_keep) == '0));

   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

   a_r9_deliver_next: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flit_valid && rx_flit_tail && (!dst_valid || dst_ready)) |=> dst_valid);

endmodule

bind tfa_flit_adapter tfa_checker #(
   .FLIT_W(FLIT_W), .MAX_SLICES(MAX_SLICES), .CFG_W(CFG_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_width     (cfg_width),
   .src_valid     (src_valid),
   .src_ready     (src_ready),
   .tx_flit_valid (tx_flit_valid),
   .tx_flit_data  (tx_flit_data),
   .tx_flit_head  (tx_flit_head),
   .tx_flit_tail  (tx_flit_tail),
   .rx_flit_valid (rx_flit_valid),
   .rx_flit_tail  (rx_flit_tail),
   .dst_valid     (dst_valid),
   .dst_ready     (dst_ready),
   .dst_data      (dst_data)
);

// File: tb/tb_tfa_flit_adapter.sv
`timescale 1ns/1ps
module tb_tfa_flit_adapter;

   localparam int FW = 150;
   localparam int NS = 4;
   localparam int WW = FW * NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [9:0]    cfg_width = '0;
   logic          src_valid = 1'b0;
   logic          src_ready;
   logic [WW-1:0] src_data = '0;
   logic          tx_v, tx_h, tx_t;
   logic [FW-1:0] tx_d;
   logic          rx_v, rx_h, rx_t;
   logic [FW-1:0] rx_d;
   logic          dst_valid;
   logic          dst_ready = 1'b0;
   logic [WW-1:0] dst_data;

   logic          use_loop = 1'b1;
   logic          b_v = 1'b0, b_h = 1'b0, b_t = 1'b0;
   logic [FW-1:0] b_d = '0;

   int n_chk = 0;
   int n_fail = 0;

   assign rx_v = use_loop ? tx_v : b_v;
   assign rx_h = use_loop ? tx_h : b_h;
   assign rx_t = use_loop ? tx_t : b_t;
   assign rx_d = use_loop ? tx_d : b_d;

   always #5 clk = ~clk;

   tfa_flit_adapter dut (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .tx_flit_valid(tx_v), .tx_flit_data(tx_d), .tx_flit_head(tx_h), .tx_flit_tail(tx_t),
      .rx_flit_valid(rx_v), .rx_flit_data(rx_d), .rx_flit_head(rx_h), .rx_flit_tail(rx_t),
      .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data)
   );

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int flits_for(input int w);
      if (w <= 150) return 1;
      if (w <= 300) return 2;
      if (w <= 450) return 3;
      return 4;
   endfunction

   function automatic logic [WW-1:0] mask_for(input int w);
      logic [WW-1:0] m;
      for (int i = 0; i < WW; i++) m[i] = (i < w);
      return m;
   endfunction

   function automatic logic [WW-1:0] pattern(input int p);
      logic [WW-1:0] v;
      for (int i = 0; i < WW; i++) begin
         case (p)
            0:       v[i] = 1'b1;
            1:       v[i] = ((i % 2) ^ ((i / 8) % 2)) == 1;
            default: v[i] = ((i * 7) % 11) < 5;
         endcase
      end
      return v;
   endfunction

   function automatic logic [FW-1:0] slice_of(input logic [WW-1:0] v, input int k);
      return FW'(v >> (FW * k));
   endfunction

   // One word through the send path and back through the loopback.
   task automatic send_one(input int w, input logic [WW-1:0] word);
      int n;
      logic [WW-1:0] exp;
      n   = flits_for(w);
      exp = word & mask_for(w);
      cfg_width = 10'(w);
      src_valid = 1'b1;
      src_data  = word;
      chk(src_ready == 1'b1, "R6 idle ready", WW'(src_ready), WW'(1));
      @(negedge clk);
      src_valid = 1'b0;
      cfg_width = 10'd5;                       // R7: change after acceptance
      for (int k = 0; k < n; k++) begin
         chk(tx_v == 1'b1, "R2 flit valid", WW'(tx_v), WW'(1));
         chk(tx_h == (k == 0), "R4 head mark", WW'(tx_h), WW'(k == 0));
         chk(tx_t == (k == n - 1), "R1 R4 R7 tail position", WW'(tx_t), WW'(k == n - 1));
         chk(tx_d == slice_of(exp, k), "R2 R3 flit data", WW'(tx_d), WW'(slice_of(exp, k)));
         if (k < n - 1) chk(src_ready == 1'b0, "R5 ready low mid word", WW'(src_ready), WW'(0));
         @(negedge clk);
      end
      chk(tx_v == 1'b0, "R6 idle after burst", WW'(tx_v), WW'(0));
      chk(dst_valid == 1'b1, "R9 valid after tail", WW'(dst_valid), WW'(1));
      chk(dst_data == exp, "R8 rebuilt word", dst_data, exp);
      @(negedge clk);
      chk(dst_valid == 1'b1 && dst_data == exp, "R9 held", dst_data, exp);
      dst_ready = 1'b1;
      @(negedge clk);
      dst_ready = 1'b0;
      chk(dst_valid == 1'b0, "R9 cleared after take", WW'(dst_valid), WW'(0));
   endtask

   initial begin
      #1_500_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int widths[12] = '{0, 1, 149, 150, 151, 300, 301, 450, 451, 599, 600, 700};
      logic [WW-1:0] wa, wb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(src_ready == 1'b1, "R6 reset ready", WW'(src_ready), WW'(1));
      chk(tx_v == 1'b0, "R6 reset tx", WW'(tx_v), WW'(0));
      chk(dst_valid == 1'b0, "R6 reset dst", WW'(dst_valid), WW'(0));

      // Band and pattern sweep.
      foreach (widths[i]) begin
         for (int p = 0; p < 3; p++) send_one(widths[i], pattern(p));
      end

      // R5: four-flit words back to back.
      wa = pattern(1);
      wb = pattern(2);
      dst_ready = 1'b1;
      cfg_width = 10'd600;
      src_valid = 1'b1;
      src_data  = wa;
      @(negedge clk);
      src_data = wb;
      for (int k = 0; k < 4; k++) begin
         chk(src_ready == (k == 3), "R5 ready only at tail", WW'(src_ready), WW'(k == 3));
         chk(tx_d == slice_of(wa, k), "R2 stream word A", WW'(tx_d), WW'(slice_of(wa, k)));
         @(negedge clk);
      end
      src_valid = 1'b0;
      chk(tx_v && tx_h, "R5 no gap before next head", WW'({tx_v, tx_h}), WW'(3));
      chk(tx_d == slice_of(wb, 0), "R5 next word first slice", WW'(tx_d), WW'(slice_of(wb, 0)));
      chk(dst_valid && dst_data == wa, "R9 stream word A delivered", dst_data, wa);
      repeat (4) @(negedge clk);
      chk(dst_valid && dst_data == wb, "R9 stream word B delivered", dst_data, wb);
      @(negedge clk);

      // R5: one-flit words on every cycle.
      cfg_width = 10'd100;
      src_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
         src_data = WW'(k + 1) << 3;
         @(negedge clk);
         chk(src_ready == 1'b1, "R5 ready with one-flit words", WW'(src_ready), WW'(1));
         chk(tx_v && tx_h && tx_t, "R4 single flit both marks", WW'({tx_v, tx_h, tx_t}), WW'(7));
         chk(tx_d == FW'((k + 1) << 3), "R2 single flit data", WW'(tx_d), WW'((k + 1) << 3));
      end
      src_valid = 1'b0;
      repeat (2) @(negedge clk);
      dst_ready = 1'b0;

      // R10: second word completes while first still held.
      cfg_width = 10'd150;
      src_valid = 1'b1;
      src_data  = WW'(150'h1234);
      @(negedge clk);
      src_data  = WW'(150'h5678);
      @(negedge clk);
      src_valid = 1'b0;
      @(negedge clk);
      chk(dst_valid && dst_data == WW'(150'h1234), "R10 first word kept", dst_data, WW'(150'h1234));
      dst_ready = 1'b1;
      @(negedge clk);
      dst_ready = 1'b0;
      chk(dst_valid == 1'b0, "R10 dropped word not delivered", WW'(dst_valid), WW'(0));

      // R8 and R11: receive path driven directly.
      use_loop = 1'b0;
      b_v = 1'b1; b_h = 1'b1; b_t = 1'b0; b_d = FW'(150'hA0);
      @(negedge clk);
      b_v = 1'b0; b_h = 1'b1; b_t = 1'b1; b_d = '1;
      @(negedge clk);
      chk(dst_valid == 1'b0, "R11 invalid tail ignored", WW'(dst_valid), WW'(0));
      b_v = 1'b1; b_h = 1'b0; b_t = 1'b0; b_d = FW'(150'hB1);
      @(negedge clk);
      b_t = 1'b1; b_d = FW'(150'hC2);
      @(negedge clk);
      b_v = 1'b0; b_t = 1'b0;
      wa = {FW'(0), FW'(150'hC2), FW'(150'hB1), FW'(150'hA0)};
      chk(dst_valid && dst_data == wa, "R8 R11 three slices filled", dst_data, wa);
      dst_ready = 1'b1;
      @(negedge clk);
      dst_ready = 1'b0;
      b_v = 1'b1; b_h = 1'b1; b_t = 1'b1; b_d = FW'(150'hD3);
      @(negedge clk);
      b_v = 1'b0;
      wb = WW'(150'hD3);
      chk(dst_valid && dst_data == wb, "R8 unsent slices zero", dst_data, wb);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule